// File: doc/BRIEF.md
# Dual-Clock Word Serializer

This block turns a stream of 10-bit parallel words into a serial bit stream. Words arrive on a slow word clock together with a valid flag, and a new word may come on every word-clock cycle. The serial line runs on a bit clock that is exactly ten times faster than the word clock and phase-aligned with it, so one full word leaves the block in each word period.

On each word-clock edge the slow side registers either the input word or, when the valid flag is low, a fixed filler word. It then inverts a one-bit strobe. The fast side keeps a copy of the strobe it last saw. When the live strobe differs from that copy, the fast side loads its shift register once, and it shifts on every other bit-clock cycle. A one-cycle frame marker tells the receiver on which bit-clock cycle the first bit of each word is on the line. The filler word is a parameter, so a code with equal numbers of ones and zeros can be used in place of all zeros.

Top module: `wordSerializer`

## Requirements
- R1: While bitRst is high and in the cycle right after it is released, serOut equals bit 0 of FILL_WORD and frameStart is 0.
- R2: The ten bits of each loaded word appear on serOut on ten consecutive bit-clock cycles, least-significant bit (bit 0) first and bit 9 last.
- R3: Once loading has started, the fast side loads exactly once every ten bit-clock cycles, so each 10-bit group is followed at once by the next group with no gap and no overlap.
- R4: The shift register is never loaded on two consecutive bit-clock cycles.
- R5: A word captured while wordValid is 0 is sent as FILL_WORD, whatever wordIn holds; a word captured while wordValid is 1 is sent as wordIn.
- R6: frameStart is high for exactly one bit-clock cycle per word, in the cycle in which bit 0 of that word is on serOut, and never on two consecutive cycles.
- R7: Bit 0 of a word captured at a word-clock rising edge is on serOut from the first bit-clock rising edge after that edge, so it is sampled 1.5 bit periods after the capturing edge.
- R8: While the word side is held in reset and the bit side runs, serOut repeats the FILL_WORD bits in the order bit 0 to bit 9 and frameStart stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wordClk | input | 1 | Slow word clock |
| wordRst | input | 1 | Synchronous reset of the word-clock side, active high |
| wordIn | input | WORD_W | Parallel word to be sent |
| wordValid | input | 1 | High when wordIn holds a real word |
| bitClk | input | 1 | Fast bit clock, WORD_W times the word clock and phase-aligned |
| bitRst | input | 1 | Synchronous reset of the bit-clock side, active high |
| serOut | output | 1 | Registered serial data, least-significant bit first |
| frameStart | output | 1 | One-cycle pulse marking bit 0 of each word on serOut |

## Verification
Where the clock edges coincide, the slow side overwrites its captured word and inverts the strobe in the same bit-clock cycle in which the fast side shifts out bit 9 of the previous word. The load of the new word then follows on the next bit-clock edge. The bench drives a new word, valid or invalid, on every word-clock cycle with no pause, so this overlap happens at every word boundary. A scoreboard rebuilds each 10-bit group starting at frameStart and compares it, in order, with the word or filler the driver queued. It also checks that the group arrives with the expected latency and that the next frame marker comes exactly ten cycles later, so a load that is lost, doubled or late shows up as a wrong group or a wrong gap.

// File: rtl/serPkg.sv
`timescale 1ns/1ps
package serPkg;
  // strobes from the control side to the datapath, bit-clock domain
  typedef struct packed {
    logic load;   // take the captured word into the shift register
    logic shift;  // advance the shift register by one bit
  } serCtrl_t;
endpackage

// File: rtl/serCtrl.sv
`timescale 1ns/1ps
module serCtrl #(
  parameter int WORD_W = 10
) (
  input  logic             wordClk,
  input  logic             wordRst,
  input  logic             bitClk,
  input  logic             bitRst,
  output serPkg::serCtrl_t ctrl,
  output logic             frameStart
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic strobe;      // inverted on every captured word, word domain
  logic seenStrobe;  // last strobe value observed, bit domain
  logic loadNow;

  always_ff @(posedge wordClk) begin
    if (wordRst) strobe <= 1'b0;
    else         strobe <= ~strobe;
  end

  assign loadNow = strobe ^ seenStrobe;

  always_ff @(posedge bitClk) begin
    if (bitRst) begin
      seenStrobe <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      seenStrobe <= strobe;
      frameStart <= loadNow;
    end
  end

  always_comb begin
    ctrl.load  = loadNow;
    ctrl.shift = ~loadNow;
  end

  // cycle spacing between loads, kept for the period check
  logic [CNT_W-1:0] gapCnt;
  logic             hadLoad;

  always_ff @(posedge bitClk) begin
    if (bitRst) begin
      gapCnt  <= '0;
      hadLoad <= 1'b0;
    end else if (loadNow) begin
      gapCnt  <= '0;
      hadLoad <= 1'b1;
    end else if (gapCnt < CNT_W'(WORD_W)) begin
      gapCnt  <= gapCnt + 1'b1;
    end
  end

  // R4: one load, then at least one cycle without
  a_r4_single_load: assert property (@(posedge bitClk) disable iff (bitRst)
    ctrl.load |=> !ctrl.load);

  // R3: loads are exactly one word period apart
  a_r3_load_period: assert property (@(posedge bitClk) disable iff (bitRst)
    (ctrl.load && hadLoad) |-> (gapCnt == CNT_W'(WORD_W - 1)));

  // R6: the frame marker is a single-cycle pulse
  a_r6_frame_pulse: assert property (@(posedge bitClk) disable iff (bitRst)
    frameStart |=> !frameStart);
endmodule

// File: rtl/serData.sv
`timescale 1ns/1ps
module serData #(
  parameter int                WORD_W    = 10,
  parameter logic [WORD_W-1:0] FILL_WORD = '0
) (
  input  logic              wordClk,
  input  logic              wordRst,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  input  logic              bitClk,
  input  logic              bitRst,
  input  serPkg::serCtrl_t  ctrl,
  output logic              serOut
);
  logic [WORD_W-1:0] capWord;
  logic [WORD_W-1:0] shiftReg;

  function automatic logic [WORD_W-1:0] rotR(input logic [WORD_W-1:0] v);
    return {v[0], v[WORD_W-1:1]};
  endfunction

  // word domain: pick real data or the filler once per word period
  always_ff @(posedge wordClk) begin
    if (wordRst)        capWord <= FILL_WORD;
    else if (wordValid) capWord <= wordIn;
    else                capWord <= FILL_WORD;
  end

  // bit domain: rotating register, so idle cycles repeat the loaded word
  always_ff @(posedge bitClk) begin
    if (bitRst) begin
      shiftReg <= rotR(FILL_WORD);
      serOut   <= FILL_WORD[0];
    end else if (ctrl.load) begin
      shiftReg <= rotR(capWord);
      serOut   <= capWord[0];
    end else if (ctrl.shift) begin
      shiftReg <= rotR(shiftReg);
      serOut   <= shiftReg[0];
    end
  end

  // R2: a load puts bit 0 of the word from the other domain on the line
  a_r2_first_bit: assert property (@(posedge bitClk) disable iff (bitRst)
    ctrl.load |=> (serOut == $past(capWord[0])));

  // R1: leaving reset, the line shows the first filler bit
  a_r1_reset_line: assert property (@(posedge bitClk) disable iff (bitRst)
    $past(bitRst) |-> (serOut == FILL_WORD[0]));
endmodule

// File: rtl/wordSerializer.sv
`timescale 1ns/1ps
module wordSerializer #(
  parameter int                WORD_W    = 10,
  parameter logic [WORD_W-1:0] FILL_WORD = '0
) (
  input  logic              wordClk,
  input  logic              wordRst,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordValid,
  input  logic              bitClk,
  input  logic              bitRst,
  output logic              serOut,
  output logic              frameStart
);
  serPkg::serCtrl_t ctrl;

  serCtrl #(.WORD_W(WORD_W)) ctrl_i (
    .wordClk    (wordClk),
    .wordRst    (wordRst),
    .bitClk     (bitClk),
    .bitRst     (bitRst),
    .ctrl       (ctrl),
    .frameStart (frameStart)
  );

  serData #(.WORD_W(WORD_W), .FILL_WORD(FILL_WORD)) data_i (
    .wordClk   (wordClk),
    .wordRst   (wordRst),
    .wordIn    (wordIn),
    .wordValid (wordValid),
    .bitClk    (bitClk),
    .bitRst    (bitRst),
    .ctrl      (ctrl),
    .serOut    (serOut)
  );
endmodule

// File: tb/wordSerializer_tb_top.sv
`timescale 1ns/1ps
module wordSerializer_tb_top;
  localparam int         W    = 10;
  localparam logic [9:0] FILL = 10'h0F8;

  logic wordClk, wordRst, wordValid, bitClk, bitRst;
  logic [W-1:0] wordIn;
  logic serOut, frameStart;

  int checks = 0;
  int fails  = 0;
  bit monOn  = 0;
  bit done   = 0;

  typedef struct {
    logic [W-1:0] w;
    bit           fill;
    longint       t;
  } item_t;
  item_t q[$];

  wordSerializer #(.WORD_W(W), .FILL_WORD(FILL)) dut_i (
    .wordClk(wordClk), .wordRst(wordRst), .wordIn(wordIn), .wordValid(wordValid),
    .bitClk(bitClk), .bitRst(bitRst), .serOut(serOut), .frameStart(frameStart)
  );

  // 125 MHz bit clock; word clock rises together with every tenth bit edge
  initial begin
    bitClk = 0;
    forever #4 bitClk = ~bitClk;
  end
  initial begin
    wordClk = 0;
    #4;
    forever begin
      wordClk = 1; #40;
      wordClk = 0; #40;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendWord(input logic [W-1:0] d, input bit v);
    item_t it;
    wordIn    = d;
    wordValid = v;
    @(posedge wordClk);
    it.w    = v ? d : FILL;
    it.fill = !v;
    it.t    = $time;
    q.push_back(it);
    @(negedge wordClk);
  endtask

  // monitor: rebuild groups from the line and score them in order
  logic [W-1:0] got;
  int           bitCnt = 0;
  bit           inFrame = 0;
  always @(negedge bitClk) begin
    if (monOn) begin
      if (frameStart) begin
        if (inFrame)
          check(bitCnt == W, "R6 frame marker spacing", bitCnt, W);
        inFrame = 1;
        bitCnt  = 1;
        got     = '0;
        got[0]  = serOut;
        if (q.size() > 0)
          check(($time - q[0].t) == 12, "R7 first bit latency", $time - q[0].t, 12);
      end else if (inFrame) begin
        if (bitCnt == W) begin
          check(1'b0, "R3 missing load after full group", 0, 1);
          inFrame = 0;
        end else begin
          got[bitCnt] = serOut;
          bitCnt++;
        end
      end
      if (inFrame && bitCnt == W && frameStart == 1'b0 && q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        if (e.fill) check(got == e.w, "R5 filler group", got, e.w);
        else        check(got == e.w, "R2 data group lsb first", got, e.w);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wordRst = 1; bitRst = 1; wordIn = '0; wordValid = 0;
    repeat (25) @(posedge bitClk);
    @(negedge bitClk);
    bitRst = 0;
    // R1: reset value still on the line
    check(serOut == FILL[0], "R1 serOut after reset", serOut, FILL[0]);
    check(frameStart == 1'b0, "R1 frameStart after reset", frameStart, 0);
    // R8: idle line repeats the filler
    for (int k = 1; k < 20; k++) begin
      @(negedge bitClk);
      check(serOut == FILL[k % W], "R8 idle filler bit", serOut, FILL[k % W]);
      check(frameStart == 1'b0, "R8 no marker while idle", frameStart, 0);
    end
    @(negedge wordClk);
    wordRst = 0;
    monOn   = 1;
    for (int i = 0; i < 8; i++) sendWord(W'($urandom), 1'b1);        // R2
    for (int i = 0; i < 8; i++) sendWord(W'($urandom), 1'b0);        // R5
    for (int i = 0; i < 10; i++) sendWord(W'($urandom), i[0]);       // R5 / R2 mixed
    sendWord(10'h000, 1'b1);
    sendWord(10'h3FF, 1'b1);
    sendWord(FILL, 1'b1);
    sendWord(10'h001, 1'b1);
    sendWord(10'h200, 1'b1);
    sendWord(10'h3FF, 1'b0);
    for (int i = 0; i < 20; i++) sendWord(W'($urandom), ($urandom % 3) != 0);
    wordValid = 0;
    repeat (3) @(negedge wordClk);
    // R3: every queued word came out
    check(q.size() == 0, "R3 words left unsent", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule